// File: doc/BRIEF.md
# Configuration-Space Target with Sized Memory Base Register

This block is the configuration side of a single memory-mapped device on a PCI-style bus. A host sends configuration reads and writes over a parallel request interface. Each request carries a strobe, a device-select qualifier, a byte offset, write data and byte enables. The block holds fixed vendor and device identifiers, a command register with a memory-decode enable, one 32-bit memory base register and an interrupt line register.

The base register shows its decode size directly. Only the upper `DEC_BITS` bits can be stored, and everything below them reads back as zero. When the host writes all ones and reads the register back, it gets a mask that gives the size of the window. The host then writes a real base address. The same masking applies to every write, so the host can size and program the register again at any time.

A comparator checks memory-cycle addresses against the stored base bits. It raises a combinational hit when decoding is enabled, and it passes the low address bits through as the offset inside the device.

Top module: `cfgt_target`

## Requirements
- R1: A request with `cfg_req` high and `cfg_sel` low is ignored. It produces no `cfg_rvalid` and changes no register.
- R2: A selected read asserts `cfg_rvalid` for one cycle, on the clock after the request, with its data on `cfg_rdata`. A selected write never asserts `cfg_rvalid`.
- R3: The register at offset 0x00 reads as device ID in bits [31:16] and vendor ID in bits [15:0]. Writes to it have no effect.
- R4: The base register is at offset 0x10. Bits [31:24] are writable. Bits [23:0] always read zero, and that includes the type field [3:0] = 0 (memory space, 32-bit, not prefetchable). Writing 0xFFFFFFFF and reading back returns 0xFF000000.
- R5: Every write to the base register is masked in the same way. Sizing and reprogramming can be repeated at any time, and the last value written wins.
- R6: The command register is at offset 0x04. Bit 1 is the memory-decode enable and is read/write. All other bits read zero.
- R7: `mem_hit` is high exactly when decoding is enabled and `mem_addr[31:24]` equals base bits [31:24]. It follows `mem_addr` combinationally.
- R8: `mem_offset` always equals `mem_addr[23:0]`.
- R9: The interrupt line register is at offset 0x3C. Bits [7:0] store any value the host writes. Bits [31:8] read zero.
- R10: Byte enable `cfg_be[i]` controls whether byte lane i (bits [8i+7:8i]) of a write is applied.
- R11: Only offset bits [7:2] pick a register, and bits [1:0] are ignored. Reads of offsets that are not implemented return zero.
- R12: After reset the base register, the command register and the interrupt line register are zero, `cfg_rvalid` is low and `mem_hit` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req | input | 1 | Configuration request strobe, one cycle per request |
| cfg_sel | input | 1 | Device select that qualifies the request |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_off | input | 8 | Byte offset into configuration space |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_rvalid | output | 1 | Read data valid, one cycle after a selected read |
| cfg_rdata | output | 32 | Read data |
| mem_addr | input | 32 | Memory-cycle address |
| mem_hit | output | 1 | Address falls in the programmed window |
| mem_offset | output | 24 | Offset of the address inside the window |

## Verification
The assertions assume that a request is held for exactly one cycle. They also assume no selected request comes in during the two cycles after `rst_n` rises, while the internal reset is still being released. A read-data check also assumes that the offset sampled with the request is the one being answered. The bench drives every request for a single clock and leaves an idle cycle after each one. It waits several cycles after reset before its first access. It changes `mem_addr` only at falling edges, so the hit-related properties see a stable address across each edge unless a configuration write happened.

// File: rtl/cfgt_pkg.sv
package cfgt_pkg;
  localparam int CFG_DW = 32;

  // Dword index of each implemented register (byte offset >> 2)
  localparam int IDX_IDENT = 0;
  localparam int IDX_CMD   = 1;
  localparam int IDX_BASE  = 4;
  localparam int IDX_IRQ   = 15;

  localparam int CMD_MEMEN_BIT = 1;
  localparam int IRQ_W         = 8;

  typedef struct packed {
    logic ident;
    logic cmd;
    logic base;
    logic irq;
  } cfgt_regsel_t;
endpackage

// File: rtl/cfgt_rst_sync.sv
module cfgt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;
endmodule

// File: rtl/cfgt_decode.sv
module cfgt_decode
  import cfgt_pkg::*;
#(
  parameter int OFF_W = 8
) (
  input  logic [OFF_W-1:0] off,
  output cfgt_regsel_t     sel
);
  localparam int IDX_W = OFF_W - 2;

  logic [IDX_W-1:0] dw_idx;

  assign dw_idx    = off[OFF_W-1:2];
  assign sel.ident = (dw_idx == IDX_W'(IDX_IDENT));
  assign sel.cmd   = (dw_idx == IDX_W'(IDX_CMD));
  assign sel.base  = (dw_idx == IDX_W'(IDX_BASE));
  assign sel.irq   = (dw_idx == IDX_W'(IDX_IRQ));
endmodule

// File: rtl/cfgt_regs.sv
module cfgt_regs
  import cfgt_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h1AB5,
  parameter logic [15:0] DEVICE_ID = 16'h0C21,
  parameter int          DEC_BITS  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  cfgt_regsel_t        sel,
  input  logic [CFG_DW-1:0]   wdata,
  input  logic [CFG_DW/8-1:0] be,
  output logic [DEC_BITS-1:0] base_hi,
  output logic                mem_en,
  output logic                rvalid,
  output logic [CFG_DW-1:0]   rdata
);
  localparam int INT_W = CFG_DW - DEC_BITS;

  logic [DEC_BITS-1:0] base_q, base_d;
  logic                memen_q, memen_d;
  logic [IRQ_W-1:0]    irq_q, irq_d;
  logic                rvalid_q, rvalid_d;
  logic [CFG_DW-1:0]   rdata_q, rdata_d;

  // Next-state: write path, masked per bit and per byte lane
  always_comb begin
    base_d  = base_q;
    memen_d = memen_q;
    irq_d   = irq_q;
    if (sel.base) begin
      for (int i = 0; i < DEC_BITS; i++) begin
        if (be[(INT_W + i) / 8]) base_d[i] = wdata[INT_W + i];
      end
    end
    if (sel.cmd && be[0]) memen_d = wdata[CMD_MEMEN_BIT];
    if (sel.irq && be[0]) irq_d   = wdata[IRQ_W-1:0];
  end

  // Next-state: read path
  always_comb begin
    rvalid_d = rd_en;
    rdata_d  = '0;
    if (sel.ident) rdata_d = {DEVICE_ID, VENDOR_ID};
    if (sel.cmd)   rdata_d[CMD_MEMEN_BIT] = memen_q;
    if (sel.base)  rdata_d[CFG_DW-1:INT_W] = base_q;
    if (sel.irq)   rdata_d[IRQ_W-1:0] = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      memen_q <= 1'b0;
      irq_q   <= '0;
    end else if (wr_en) begin
      base_q  <= base_d;
      memen_q <= memen_d;
      irq_q   <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rvalid_d;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign base_hi = base_q;
  assign mem_en  = memen_q;
  assign rvalid  = rvalid_q;
  assign rdata   = rdata_q;
endmodule

// File: rtl/cfgt_match.sv
module cfgt_match #(
  parameter int ADDR_W   = 32,
  parameter int DEC_BITS = 8
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DEC_BITS-1:0]        base_hi,
  input  logic                       mem_en,
  output logic                       hit,
  output logic [ADDR_W-DEC_BITS-1:0] offset
);
  assign hit    = mem_en && (addr[ADDR_W-1:ADDR_W-DEC_BITS] == base_hi);
  assign offset = addr[ADDR_W-DEC_BITS-1:0];
endmodule

// File: rtl/cfgt_target.sv
module cfgt_target
  import cfgt_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h1AB5,
  parameter logic [15:0] DEVICE_ID = 16'h0C21,
  parameter int          DEC_BITS  = 8,
  parameter int          OFF_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_req,
  input  logic                       cfg_sel,
  input  logic                       cfg_we,
  input  logic [OFF_W-1:0]           cfg_off,
  input  logic [CFG_DW-1:0]          cfg_wdata,
  input  logic [CFG_DW/8-1:0]        cfg_be,
  output logic                       cfg_rvalid,
  output logic [CFG_DW-1:0]          cfg_rdata,
  input  logic [CFG_DW-1:0]          mem_addr,
  output logic                       mem_hit,
  output logic [CFG_DW-DEC_BITS-1:0] mem_offset
);
  logic                rst_n_int;
  logic                access;
  logic                wr_en;
  logic                rd_en;
  cfgt_regsel_t        sel;
  logic [DEC_BITS-1:0] base_hi;
  logic                mem_en;

  assign access = cfg_req && cfg_sel;
  assign wr_en  = access && cfg_we;
  assign rd_en  = access && !cfg_we;

  cfgt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  cfgt_decode #(.OFF_W(OFF_W)) u_dec (
    .off (cfg_off),
    .sel (sel)
  );

  cfgt_regs #(
    .VENDOR_ID (VENDOR_ID),
    .DEVICE_ID (DEVICE_ID),
    .DEC_BITS  (DEC_BITS)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .sel     (sel),
    .wdata   (cfg_wdata),
    .be      (cfg_be),
    .base_hi (base_hi),
    .mem_en  (mem_en),
    .rvalid  (cfg_rvalid),
    .rdata   (cfg_rdata)
  );

  cfgt_match #(.ADDR_W(CFG_DW), .DEC_BITS(DEC_BITS)) u_match (
    .addr    (mem_addr),
    .base_hi (base_hi),
    .mem_en  (mem_en),
    .hit     (mem_hit),
    .offset  (mem_offset)
  );
endmodule

// File: rtl/cfgt_target_chk.sv
module cfgt_target_chk #(
  parameter logic [15:0] VENDOR_ID = 16'h1AB5,
  parameter logic [15:0] DEVICE_ID = 16'h0C21,
  parameter int          DEC_BITS  = 8,
  parameter int          OFF_W     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_req,
  input logic                 cfg_sel,
  input logic                 cfg_we,
  input logic [OFF_W-1:0]     cfg_off,
  input logic [31:0]          cfg_rdata,
  input logic                 cfg_rvalid,
  input logic [31:0]          mem_addr,
  input logic                 mem_hit
);
  localparam int INT_W = 32 - DEC_BITS;
  localparam int IDX_W = OFF_W - 2;

  logic rd_sel;
  assign rd_sel = cfg_req && cfg_sel && !cfg_we;

  assert_unselected_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_req && cfg_sel) |=> !cfg_rvalid);

  assert_read_answered_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel |=> cfg_rvalid);

  assert_ident_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel && cfg_off[OFF_W-1:2] == IDX_W'(0)) |=> cfg_rdata == {DEVICE_ID, VENDOR_ID});

  assert_base_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel && cfg_off[OFF_W-1:2] == IDX_W'(4)) |=> cfg_rdata[INT_W-1:0] == '0);

  assert_irq_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel && cfg_off[OFF_W-1:2] == IDX_W'(15)) |=> cfg_rdata[31:8] == '0);

  // R7: with a steady address, a hit can only appear after a configuration write
  assert_hit_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_hit) && $stable(mem_addr)) |-> $past(cfg_req && cfg_sel && cfg_we));
endmodule

bind cfgt_target cfgt_target_chk #(
  .VENDOR_ID (VENDOR_ID),
  .DEVICE_ID (DEVICE_ID),
  .DEC_BITS  (DEC_BITS),
  .OFF_W     (OFF_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_req    (cfg_req),
  .cfg_sel    (cfg_sel),
  .cfg_we     (cfg_we),
  .cfg_off    (cfg_off),
  .cfg_rdata  (cfg_rdata),
  .cfg_rvalid (cfg_rvalid),
  .mem_addr   (mem_addr),
  .mem_hit    (mem_hit)
);

// File: tb/cfgt_target_test.sv
module cfgt_target_test;
  localparam logic [15:0] VEN = 16'h1AB5;
  localparam logic [15:0] DEV = 16'h0C21;

  logic        clk;
  logic        rst_n;
  logic        cfg_req, cfg_sel, cfg_we;
  logic [7:0]  cfg_off;
  logic [31:0] cfg_wdata;
  logic [3:0]  cfg_be;
  logic        cfg_rvalid;
  logic [31:0] cfg_rdata;
  logic [31:0] mem_addr;
  logic        mem_hit;
  logic [23:0] mem_offset;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_base;
  logic       m_memen;
  logic [7:0] m_irq;

  cfgt_target #(.VENDOR_ID(VEN), .DEVICE_ID(DEV)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_sel(cfg_sel),
    .cfg_we(cfg_we), .cfg_off(cfg_off), .cfg_wdata(cfg_wdata), .cfg_be(cfg_be),
    .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata), .mem_addr(mem_addr),
    .mem_hit(mem_hit), .mem_offset(mem_offset)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] off);
    case (off[7:2])
      6'd0:    return {DEV, VEN};
      6'd1:    return {30'b0, m_memen, 1'b0};
      6'd4:    return {m_base, 24'b0};
      6'd15:   return {24'b0, m_irq};
      default: return 32'b0;
    endcase
  endfunction

  function automatic bit exp_hit(input logic [31:0] a);
    return m_memen && (a[31:24] == m_base);
  endfunction

  task automatic cfg_wr(input bit sel, input logic [7:0] off, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_req = 1'b1; cfg_sel = sel; cfg_we = 1'b1; cfg_off = off; cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    chk(cfg_rvalid == 1'b0, "R2 write gives no rvalid", {31'b0, cfg_rvalid}, 32'b0);
    cfg_req = 1'b0; cfg_sel = 1'b0;
    if (sel) begin
      case (off[7:2])
        6'd1:  if (be[0]) m_memen = d[1];
        6'd4:  if (be[3]) m_base = d[31:24];
        6'd15: if (be[0]) m_irq = d[7:0];
        default: ;
      endcase
    end
  endtask

  task automatic cfg_rd(input bit sel, input logic [7:0] off, input string req);
    logic [31:0] e;
    e = exp_rd(off);
    @(negedge clk);
    cfg_req = 1'b1; cfg_sel = sel; cfg_we = 1'b0; cfg_off = off;
    @(negedge clk);
    if (sel) begin
      chk(cfg_rvalid == 1'b1, {req, " rvalid (R2)"}, {31'b0, cfg_rvalid}, 32'd1);
      chk(cfg_rdata == e, req, cfg_rdata, e);
    end else begin
      chk(cfg_rvalid == 1'b0, {req, " unselected read silent (R1)"}, {31'b0, cfg_rvalid}, 32'd0);
    end
    cfg_req = 1'b0; cfg_sel = 1'b0;
  endtask

  task automatic mem_chk(input logic [31:0] a, input string req);
    @(negedge clk);
    mem_addr = a;
    #1;
    chk(mem_hit == exp_hit(a), {req, " hit"}, {31'b0, mem_hit}, {31'b0, exp_hit(a)});
    chk(mem_offset == a[23:0], "R8 offset passthrough", {8'b0, mem_offset}, {8'b0, a[23:0]});
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      report();
    end
  end

  initial begin
    logic [7:0] off;
    logic [31:0] a;
    cfg_req = 0; cfg_sel = 0; cfg_we = 0; cfg_off = 0; cfg_wdata = 0; cfg_be = 0;
    mem_addr = 32'h0;
    m_base = 0; m_memen = 0; m_irq = 0;
    rst_n = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R12 reset state
    chk(cfg_rvalid == 1'b0, "R12 rvalid after reset", {31'b0, cfg_rvalid}, 32'd0);
    mem_chk(32'h0000_1234, "R12 no hit after reset");
    cfg_rd(1, 8'h10, "R12 base reset");
    cfg_rd(1, 8'h04, "R12 command reset");
    cfg_rd(1, 8'h3C, "R12 irq reset");

    // R3 identifiers, write ignored
    cfg_rd(1, 8'h00, "R3 ident");
    cfg_wr(1, 8'h00, 32'h0000_0000, 4'hF);
    cfg_rd(1, 8'h00, "R3 ident after write");

    // R4 sizing
    cfg_wr(1, 8'h10, 32'hFFFF_FFFF, 4'hF);
    cfg_rd(1, 8'h10, "R4 sizing mask");
    chk(exp_rd(8'h10) == 32'hFF00_0000, "R4 mask constant", exp_rd(8'h10), 32'hFF00_0000);

    // R10 byte enables: no lane 3 means no base change
    cfg_wr(1, 8'h10, 32'h4200_0000, 4'b0111);
    cfg_rd(1, 8'h10, "R10 base unchanged without lane 3");
    cfg_wr(1, 8'h10, 32'h42AB_CDEF, 4'b1000);
    cfg_rd(1, 8'h10, "R4 program base");

    // R1 unselected write ignored
    cfg_wr(0, 8'h10, 32'h9900_0000, 4'hF);
    cfg_rd(1, 8'h10, "R1 base after unselected write");
    cfg_rd(0, 8'h10, "R1 unselected read");

    // R7 decode gated by enable
    mem_chk(32'h4212_3456, "R7 disabled");
    cfg_wr(1, 8'h04, 32'hFFFF_FFFF, 4'b1110);
    cfg_rd(1, 8'h04, "R10 command lane 0 off");
    cfg_wr(1, 8'h04, 32'hFFFF_FFFF, 4'hF);
    cfg_rd(1, 8'h04, "R6 command only bit 1");
    mem_chk(32'h4212_3456, "R7 enabled match");
    mem_chk(32'h4312_3456, "R7 enabled miss");
    mem_chk(32'h41FF_FFFF, "R7 boundary below");

    // R11 low offset bits ignored, unimplemented zero
    cfg_rd(1, 8'h13, "R11 offset bits 1:0 ignored");
    cfg_rd(1, 8'h08, "R11 unimplemented zero");
    cfg_rd(1, 8'hFC, "R11 top offset zero");

    // R9 interrupt line
    cfg_wr(1, 8'h3C, 32'hDEAD_BEA5, 4'hF);
    cfg_rd(1, 8'h3C, "R9 irq value");

    // R5 resize after programming, then reprogram
    cfg_wr(1, 8'h10, 32'hFFFF_FFFF, 4'hF);
    cfg_rd(1, 8'h10, "R5 resize mask");
    mem_chk(32'hFF00_0010, "R5 hit at all-ones base");
    cfg_wr(1, 8'h10, 32'h8000_0000, 4'hF);
    cfg_rd(1, 8'h10, "R5 reprogram");
    mem_chk(32'h80FE_DCBA, "R5 hit new base");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      case ($urandom % 6)
        0: off = 8'h00;
        1: off = 8'h04 | 8'($urandom % 4);
        2: off = 8'h10 | 8'($urandom % 4);
        3: off = 8'h3C;
        default: off = 8'($urandom);
      endcase
      case ($urandom % 3)
        0: cfg_wr(($urandom % 4) != 0, off, $urandom, 4'($urandom));
        1: cfg_rd(($urandom % 4) != 0, off, "R11 random read");
        default: begin
          a = $urandom;
          if ($urandom % 2) a[31:24] = m_base;
          mem_chk(a, "R7 random");
        end
      endcase
    end

    done = 1;
    report();
  end
endmodule